// File: doc/BRIEF.md
# PCM Highway Signaling Slot Inserter

This block drives one channel's transmit data onto a time-division PCM highway. A frame begins when frame sync is sampled high. The channel's programmed slot number selects an 8-clock window, and the block shifts the companded voice byte out there, most significant bit first. The serial data and its drive-enable are registered. The enable is low wherever the channel does not own the line, so a tri-state buffer outside the block can release the highway there.

When signaling mode is on and the channel uses A-law or µ-law, the channel also takes the next time slot. That slot carries a status byte assembled from three line-status inputs: the primary detector, the secondary detector and the clock-fail flag. The status slot follows the voice slot with no gap. It stays driven even when the channel is inactive, while the voice slot needs the channel to be active. Voice byte, status bits and the mode controls are all sampled once, at the first bit of the voice slot, so the bytes on the line cannot change partway through.

Top module: `pcm_sig_slot_tx`

## Requirements
- R1: After reset, hw_oe and hw_data are both 0.
- R2: Before the first frame sync, and in every bit position outside the channel's driven slots, hw_oe is 0.
- R3: Bit position p counts from 0, which is the first clock after frame sync is sampled high. The voice slot covers positions slot_num*8 to slot_num*8+7 and carries voice_byte MSB first. It is driven (hw_oe=1) only when chan_active is 1.
- R4: The signaling slot covers positions slot_num*8+8 to slot_num*8+15. Its bit 7 goes out on the clock immediately after voice bit 0.
- R5: The signaling byte is {det_pri, det_sec, 3'b000, clk_fail, 2'b00}: bit 7 is the primary detector, bit 6 the secondary detector, bit 2 the clock-fail flag, and the reserved bits 5..3 and 1..0 are 0.
- R6: The signaling slot is driven only when sig_mode_en is 1 and cmp_mode is A-law (2'b01) or µ-law (2'b10). The codes 2'b00 (linear) and 2'b11 (reserved) leave it undriven.
- R7: The signaling slot is driven regardless of chan_active.
- R8: voice_byte, det_pri, det_sec, clk_fail, chan_active, sig_mode_en and cmp_mode are sampled at the first voice-slot position. Later changes within that frame's slots have no effect.
- R9: When sig_mode_en is 0, the channel drives only its voice slot.
- R10: hw_data is 0 whenever hw_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fs | input | 1 | Frame sync, sampled on the rising edge |
| slot_num | input | SLOT_W | Programmed voice time slot |
| cmp_mode | input | 2 | 00 linear, 01 A-law, 10 µ-law, 11 reserved |
| sig_mode_en | input | 1 | Enables the trailing signaling slot |
| chan_active | input | 1 | Channel active; gates the voice slot |
| voice_byte | input | 8 | Companded voice sample |
| det_pri | input | 1 | Debounced primary detector status |
| det_sec | input | 1 | Secondary detector status |
| clk_fail | input | 1 | Clock-fail status |
| hw_data | output | 1 | Serial highway data |
| hw_oe | output | 1 | Drive-enable for hw_data |

## Verification
Assertions check four properties on every cycle. The data line is quiet while the enable is low. The signaling slot's enable follows the sampled mode controls. The last voice bit is followed directly by a driven signaling bit. The reserved bit positions and the leading status bit carry the correct values. Only the bench's sweeps can show three further things. First, each slot lands at the exact position for every slot number. Second, each mode and activity combination gives the right set of driven slots. Third, changing the voice and status inputs partway through a slot leaves the bytes already on the line untouched.

// File: rtl/pcm_sig_pkg.sv
package pcm_sig_pkg;
  typedef enum logic [1:0] {
    CMP_LINEAR = 2'b00,
    CMP_ALAW   = 2'b01,
    CMP_ULAW   = 2'b10,
    CMP_RSVD   = 2'b11
  } cmp_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IDX_W = 3;

  function automatic logic is_companded(input logic [1:0] m);
    return (m == CMP_ALAW) || (m == CMP_ULAW);
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic [SLOT_W-1:0] slot_num,
  output logic              voice_start,
  output logic              in_voice,
  output logic              in_sig,
  output logic [2:0]        bit_idx
);
  localparam int unsigned POS_W = SLOT_W + 4;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_n;
  logic             run_q, run_n;
  logic [SLOT_W:0]  slot_ext;

  assign slot_ext = {1'b0, slot_num};
  assign pos_n    = fs ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1);
  assign run_n    = fs | run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_MAX;
      run_q <= 1'b0;
    end else begin
      pos_q <= pos_n;
      run_q <= run_n;
    end
  end

  assign in_voice    = run_n && (pos_n[POS_W-1:3] == slot_ext);
  assign in_sig      = run_n && (pos_n[POS_W-1:3] == slot_ext + 1'b1);
  assign bit_idx     = pos_n[2:0];
  assign voice_start = in_voice && (pos_n[2:0] == 3'd0);
endmodule

// File: rtl/pcm_status_pack.sv
module pcm_status_pack (
  input  logic       det_pri,
  input  logic       det_sec,
  input  logic       clk_fail,
  output logic [7:0] stat_byte
);
  always_comb begin
    stat_byte    = '0;
    stat_byte[7] = det_pri;
    stat_byte[6] = det_sec;
    stat_byte[2] = clk_fail;
  end
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter
  import pcm_sig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       voice_start,
  input  logic       in_voice,
  input  logic       in_sig,
  input  logic [2:0] bit_idx,
  input  logic       chan_active,
  input  logic       sig_mode_en,
  input  logic [1:0] cmp_mode,
  input  logic [7:0] voice_byte,
  input  logic [7:0] stat_byte,
  output logic       hw_data,
  output logic       hw_oe
);
  localparam int unsigned SH_W = 2 * BYTE_W;

  logic [SH_W-1:0] sh_q;
  logic [7:0]      stat_q;
  logic            act_q, sig_en_q;
  logic            voice_ph_q, sig_ph_q;
  logic [2:0]      idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      stat_q     <= '0;
      act_q      <= 1'b0;
      sig_en_q   <= 1'b0;
      voice_ph_q <= 1'b0;
      sig_ph_q   <= 1'b0;
      idx_q      <= '0;
      hw_data    <= 1'b0;
      hw_oe      <= 1'b0;
    end else begin
      voice_ph_q <= in_voice;
      sig_ph_q   <= in_sig;
      idx_q      <= bit_idx;
      if (voice_start) begin
        act_q    <= chan_active;
        sig_en_q <= sig_mode_en && is_companded(cmp_mode);
        stat_q   <= stat_byte;
        sh_q     <= {voice_byte[6:0], stat_byte, 1'b0};
        hw_oe    <= chan_active;
        hw_data  <= chan_active & voice_byte[7];
      end else if (in_voice || in_sig) begin
        sh_q    <= {sh_q[SH_W-2:0], 1'b0};
        hw_oe   <= in_voice ? act_q : sig_en_q;
        hw_data <= (in_voice ? act_q : sig_en_q) & sh_q[SH_W-1];
      end else begin
        hw_oe   <= 1'b0;
        hw_data <= 1'b0;
      end
    end
  end

  // R10: quiet line when not driving
  p_quiet_line_r10: assert property (@(posedge clk) disable iff (rst)
    !hw_oe |-> !hw_data);

  // R7: signaling slot enable follows sampled mode only, not activity
  p_sig_enable_r7: assert property (@(posedge clk) disable iff (rst)
    sig_ph_q |-> (hw_oe == sig_en_q));

  // R4: last voice bit is followed directly by a driven signaling bit
  p_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
    (voice_ph_q && idx_q == 3'd7 && sig_en_q) |=> (hw_oe && sig_ph_q));

  // R5: reserved positions are 0 and the leading bit is the primary detector
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (sig_ph_q && hw_oe && (idx_q == 3'd2 || idx_q == 3'd3 || idx_q == 3'd4 ||
                           idx_q == 3'd6 || idx_q == 3'd7)) |-> !hw_data);

  p_lead_status_r5: assert property (@(posedge clk) disable iff (rst)
    (sig_ph_q && hw_oe && idx_q == 3'd0) |-> (hw_data == stat_q[7]));
endmodule

// File: rtl/pcm_sig_slot_tx.sv
module pcm_sig_slot_tx #(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [1:0]        cmp_mode,
  input  logic              sig_mode_en,
  input  logic              chan_active,
  input  logic [7:0]        voice_byte,
  input  logic              det_pri,
  input  logic              det_sec,
  input  logic              clk_fail,
  output logic              hw_data,
  output logic              hw_oe
);
  logic       voice_start, in_voice, in_sig;
  logic [2:0] bit_idx;
  logic [7:0] stat_byte;

  pcm_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .fs(fs), .slot_num(slot_num),
    .voice_start(voice_start), .in_voice(in_voice), .in_sig(in_sig),
    .bit_idx(bit_idx)
  );

  pcm_status_pack u_pack (
    .det_pri(det_pri), .det_sec(det_sec), .clk_fail(clk_fail),
    .stat_byte(stat_byte)
  );

  pcm_slot_shifter u_shift (
    .clk(clk), .rst(rst), .voice_start(voice_start), .in_voice(in_voice),
    .in_sig(in_sig), .bit_idx(bit_idx), .chan_active(chan_active),
    .sig_mode_en(sig_mode_en), .cmp_mode(cmp_mode), .voice_byte(voice_byte),
    .stat_byte(stat_byte), .hw_data(hw_data), .hw_oe(hw_oe)
  );
endmodule

// File: tb/test_pcm_sig_slot_tx.sv
module test_pcm_sig_slot_tx;
  localparam int unsigned SLOT_W = 3;
  localparam int unsigned NSLOT = 1 << SLOT_W;
  localparam int unsigned FRAME_BITS = NSLOT * 8 + 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1, fs = 1'b0;
  logic [SLOT_W-1:0] slot_num = '0;
  logic [1:0] cmp_mode = 2'b00;
  logic sig_mode_en = 1'b0, chan_active = 1'b0;
  logic [7:0] voice_byte = '0;
  logic det_pri = 1'b0, det_sec = 1'b0, clk_fail = 1'b0;
  logic hw_data, hw_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_sig_slot_tx #(.SLOT_W(SLOT_W)) i_pcm_sig_slot_tx (
    .clk(clk), .rst(rst), .fs(fs), .slot_num(slot_num), .cmp_mode(cmp_mode),
    .sig_mode_en(sig_mode_en), .chan_active(chan_active),
    .voice_byte(voice_byte), .det_pri(det_pri), .det_sec(det_sec),
    .clk_fail(clk_fail), .hw_data(hw_data), .hw_oe(hw_oe)
  );

  task automatic check(input string req, input logic got_oe, input logic got_d,
                       input logic exp_oe, input logic exp_d, input int pos);
    checks++;
    if (got_oe !== exp_oe || got_d !== exp_d) begin
      failures++;
      $display("FAIL %s pos=%0d actual oe=%b d=%b expected oe=%b d=%b",
               req, pos, got_oe, got_d, exp_oe, exp_d);
    end
  endtask

  task automatic run_frame(input int slot, input int mode, input bit smode,
                           input bit act);
    logic [7:0] v, st;
    int base;
    bit sig_on;
    v  = 8'($urandom);
    st = 8'($urandom);
    base = slot * 8;
    sig_on = smode && (mode == 1 || mode == 2);
    @(negedge clk);
    fs = 1'b1; slot_num = SLOT_W'(slot); cmp_mode = 2'(mode);
    sig_mode_en = smode; chan_active = act; voice_byte = v;
    det_pri = st[7]; det_sec = st[6]; clk_fail = st[2];
    @(negedge clk);
    fs = 1'b0;
    for (int p = 0; p < FRAME_BITS; p++) begin
      logic eo, ed;
      string rq;
      if (p >= base && p < base + 8) begin
        eo = act; ed = act & v[7 - (p - base)]; rq = "R3/R7/R8";
      end else if (p >= base + 8 && p < base + 16) begin
        eo = sig_on;
        ed = sig_on & ({st[7], st[6], 3'b000, st[2], 2'b00} >> (7 - (p - base - 8))) & 1'b1;
        rq = smode ? "R4/R5/R6/R7/R8" : "R9";
      end else begin
        eo = 1'b0; ed = 1'b0; rq = "R2/R10";
      end
      check(rq, hw_oe, hw_data, eo, ed, p);
      if (p == base + 2) begin
        // R8: inputs changed mid-slot must not alter the bytes on the line
        voice_byte = ~v; det_pri = ~st[7]; det_sec = ~st[6]; clk_fail = ~st[2];
        chan_active = ~act; sig_mode_en = ~smode; cmp_mode = 2'(mode ^ 3);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", hw_oe, hw_data, 1'b0, 1'b0, -1);
    rst = 1'b0;
    chan_active = 1'b1; sig_mode_en = 1'b1; cmp_mode = 2'b10; voice_byte = 8'hFF;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R2", hw_oe, hw_data, 1'b0, 1'b0, i);
    end
    for (int s = 0; s < NSLOT; s++)
      for (int m = 0; m < 4; m++)
        for (int sm = 0; sm < 2; sm++)
          for (int a = 0; a < 2; a++)
            run_frame(s, m, sm[0], a[0]);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule